// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital controller of a 14-bit successive-approximation converter. A host talks to it through an active-low chip select, a read/convert level, a byte select and an 8-bit output bus with an output enable. The chip select falls three times per sample. The first fall, with the read/convert level low, wakes the block and starts acquisition. The second fall ends acquisition and starts conversion. The read/convert level sampled at that second fall chooses whether the reference stays powered after the conversion. The third fall, with the read/convert level high, puts the result on the bus.

The analog side is abstracted away. A one-bit comparator decision arrives on `cmpIn`, and the internal conversion clock is a count of system clock cycles. The sequencer runs one trial per result bit, MSB first. It lowers an end-of-conversion flag when the result is latched and reports the power state of the reference on `refOn`. The code is the plain binary word of the comparator decisions. A bipolar front end reads the same word as offset binary, where `10 0000 0000 0000` is mid-scale.

The inputs are taken as synchronous to `clk`. Acquisition and reference settling are measured in cycles through the parameters `ACQ_CYCLES` (standby path) and `WAKE_CYCLES` (shutdown path, at least `ACQ_CYCLES`). Each bit trial lasts `BIT_CYCLES` cycles.

Top module: `sar_seq_ctrl`

## Requirements
- R1: In the idle state, a chip-select fall sampled with `rdConv` low starts acquisition and sets `refOn` to 1 on the next cycle. A fall sampled with `rdConv` high is ignored, and `refOn`, `eocN` and the bus keep their values.
- R2: Acquisition lasts `WAKE_CYCLES` cycles when it starts with `refOn` at 0, and `ACQ_CYCLES` cycles when `refOn` is already 1. A second fall sampled before that window has elapsed is ignored, and acquisition continues.
- R3: After the window, a second fall starts conversion and samples `rdConv`. If `rdConv` was 0, `refOn` stays 1. If it was 1, `refOn` drops to 0 in the same cycle that `eocN` falls.
- R4: Conversion runs `RES_BITS` trials, MSB first, each lasting `BIT_CYCLES` cycles. `cmpIn` is sampled in the last cycle of each trial, and a 1 keeps the trial bit. `eocN` goes low exactly `RES_BITS*BIT_CYCLES` cycles after the edge that sampled the second fall, and the result is valid from that same cycle.
- R5: `dataOe` is 0 and `dataOut` is all zeros at every time except readout. This includes acquisition, conversion and the wait for readout.
- R6: During readout, `hiByteSel`=1 drives the result bits 13..8 on `dataOut[5:0]`, with `dataOut[7:6]`=0. `hiByteSel`=0 drives result bits 7..0. The byte follows `hiByteSel` in the same cycle.
- R7: After `eocN` falls, a chip-select fall sampled with `rdConv` high starts readout, and `dataOe` is 1 from the next cycle. A fall sampled with `rdConv` low is ignored, and the bus stays off.
- R8: When `csN` is sampled high during readout, `dataOe` goes to 0 and `eocN` returns to 1 on the next cycle. The block then waits for a new first fall.
- R9: After reset, `eocN`=1, `refOn`=0 and `dataOe`=0.
- R10: Chip-select falls during conversion are ignored. The conversion timing and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select; its falling edges drive the protocol |
| rdConv | input | 1 | Read/convert qualifier, sampled on each chip-select fall |
| hiByteSel | input | 1 | 1 selects the upper result byte, 0 the lower |
| cmpIn | input | 1 | Comparator decision for the current trial (1 = keep bit) |
| dataOut | output | 8 | Result byte; zero when the bus is off |
| dataOe | output | 1 | Output enable for the tri-state pad driver |
| eocN | output | 1 | End of conversion, low while a result is held |
| refOn | output | 1 | Reference and buffer powered (standby) when 1, shut down when 0 |

## Verification
Every result lands a known number of cycles after the edge that samples its stimulus. `refOn` and `dataOe` change one cycle after the sampled fall. `eocN` falls `RES_BITS*BIT_CYCLES` cycles after the second fall. `dataOut` follows `hiByteSel` with no register in between. The bench drives inputs 2 ns after a rising edge and runs a behavioural model on the same rising edges. It compares all four outputs against that model on every falling edge. Targeted checks land on the exact cycle: one cycle before and on the cycle `eocN` is due, and a 1 ns settle after each `hiByteSel` change.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACQ  = 3'd1,
    ST_CONV = 3'd2,
    ST_DONE = 3'd3,
    ST_READ = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic convStart;  // load first trial
    logic bitTick;    // resolve current trial
    logic lastBit;    // final trial, latch result
    logic busEn;      // drive the output bus
  } ctrlStrobes_t;

endpackage

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t stb,
  input  logic         cmpIn,
  input  logic         hiByteSel,
  output logic [7:0]   dataOut,
  output logic         dataOe
);

  localparam int HI_BITS = RES_BITS - 8;
  localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sarReg;
  logic [RES_BITS-1:0] trialMask;
  logic [RES_BITS-1:0] resultReg;
  logic [RES_BITS-1:0] decided;
  logic [7:0]          byteLo;
  logic [7:0]          byteHi;

  // keep or clear the bit under trial
  always_comb begin
    decided = cmpIn ? sarReg : (sarReg & ~trialMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg    <= '0;
      trialMask <= '0;
      resultReg <= '0;
    end else begin
      if (stb.convStart) begin
        sarReg    <= MSB_MASK;
        trialMask <= MSB_MASK;
      end else if (stb.bitTick) begin
        sarReg    <= decided | (trialMask >> 1);
        trialMask <= trialMask >> 1;
      end
      if (stb.lastBit) begin
        resultReg <= decided;
      end
    end
  end

  assign byteLo = resultReg[7:0];

  generate
    if (HI_BITS >= 8) begin : g_fullHi
      assign byteHi = resultReg[15:8];
    end else begin : g_padHi
      assign byteHi = {{(8-HI_BITS){1'b0}}, resultReg[RES_BITS-1:8]};
    end
  endgenerate

  always_comb begin
    if (stb.busEn) begin
      dataOut = hiByteSel ? byteHi : byteLo;
    end else begin
      dataOut = '0;
    end
  end

  assign dataOe = stb.busEn;

  // R4: result only moves on the control's latch strobe
  a_r4_result_hold : assert property (@(posedge clk) disable iff (!rstN)
    !stb.lastBit |=> $stable(resultReg));

  // R6: unused top bits of the upper byte read as zero
  a_r6_hi_pad_zero : assert property (@(posedge clk) disable iff (!rstN)
    (stb.busEn && hiByteSel) |-> (dataOut[7:6] == 2'b00));

endmodule

// File: rtl/sar_seq_ctrl_fsm.sv
module sar_seq_ctrl_fsm
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 14,
  parameter int ACQ_CYCLES  = 200,
  parameter int WAKE_CYCLES = 1200000,
  parameter int BIT_CYCLES  = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rdConv,
  output ctrlStrobes_t stb,
  output logic         eocN,
  output logic         refOn
);

  localparam int TMR_MAX  = (WAKE_CYCLES > ACQ_CYCLES) ? WAKE_CYCLES : ACQ_CYCLES;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int CYC_W    = $clog2(BIT_CYCLES + 1);
  localparam int BIT_W    = $clog2(RES_BITS + 1);
  localparam int CONV_LEN = RES_BITS * BIT_CYCLES;
  localparam int AGE_W    = $clog2(CONV_LEN + 2);

  seqState_t        state;
  logic [TMR_W-1:0] acqTimer;
  logic [CYC_W-1:0] cycCnt;
  logic [BIT_W-1:0] bitsLeft;
  logic             csPrev;
  logic             csFall;
  logic             shutAfter;
  logic             acqDone;
  logic             trialEnd;

  assign csFall   = csPrev & ~csN;
  assign acqDone  = (acqTimer == '0);
  assign trialEnd = (cycCnt == CYC_W'(BIT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      acqTimer  <= '0;
      cycCnt    <= '0;
      bitsLeft  <= '0;
      csPrev    <= 1'b1;
      shutAfter <= 1'b1;
      refOn     <= 1'b0;
      eocN      <= 1'b1;
    end else begin
      csPrev <= csN;
      unique case (state)
        ST_IDLE: begin
          if (csFall && !rdConv) begin
            state    <= ST_ACQ;
            acqTimer <= refOn ? TMR_W'(ACQ_CYCLES) : TMR_W'(WAKE_CYCLES);
            refOn    <= 1'b1;
          end
        end
        ST_ACQ: begin
          if (!acqDone) begin
            acqTimer <= acqTimer - 1'b1;
          end else if (csFall) begin
            state     <= ST_CONV;
            shutAfter <= rdConv;
            cycCnt    <= '0;
            bitsLeft  <= BIT_W'(RES_BITS - 1);
          end
        end
        ST_CONV: begin
          if (trialEnd) begin
            cycCnt <= '0;
            if (bitsLeft == '0) begin
              state <= ST_DONE;
              eocN  <= 1'b0;
              if (shutAfter) begin
                refOn <= 1'b0;
              end
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
            end
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_DONE: begin
          if (csFall && rdConv) begin
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (csN) begin
            state <= ST_IDLE;
            eocN  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.convStart = (state == ST_ACQ) && acqDone && csFall;
    stb.bitTick   = (state == ST_CONV) && trialEnd;
    stb.lastBit   = (state == ST_CONV) && trialEnd && (bitsLeft == '0);
    stb.busEn     = (state == ST_READ);
  end

  // conversion age, used only to bound the conversion window
  logic [AGE_W-1:0] convAge;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      convAge <= '0;
    end else if (stb.convStart) begin
      convAge <= '0;
    end else if (state == ST_CONV) begin
      convAge <= convAge + 1'b1;
    end
  end

  // R1: a fall with rdConv high leaves the idle state untouched
  a_r1_idle_ignore : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdConv) |=> (state == ST_IDLE));

  // R2: no conversion while the acquisition window is still open
  a_r2_window_hold : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACQ && !acqDone) |=> (state == ST_ACQ));

  // R3: standby choice keeps the reference on through completion
  a_r3_standby_ref : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !shutAfter) |=> refOn);

  // R4: conversion never outlasts its trial budget
  a_r4_conv_bound : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |-> (convAge < AGE_W'(CONV_LEN)));

  // R8: raising chip select ends readout and releases the flag
  a_r8_release : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && csN) |=> (eocN && !stb.busEn));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 14,
  parameter int ACQ_CYCLES  = 200,
  parameter int WAKE_CYCLES = 1200000,
  parameter int BIT_CYCLES  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdConv,
  input  logic       hiByteSel,
  input  logic       cmpIn,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       eocN,
  output logic       refOn
);

  ctrlStrobes_t stb;

  sar_seq_ctrl_fsm #(
    .RES_BITS   (RES_BITS),
    .ACQ_CYCLES (ACQ_CYCLES),
    .WAKE_CYCLES(WAKE_CYCLES),
    .BIT_CYCLES (BIT_CYCLES)
  ) u_fsm (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .rdConv(rdConv),
    .stb   (stb),
    .eocN  (eocN),
    .refOn (refOn)
  );

  sar_seq_datapath #(
    .RES_BITS(RES_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmpIn    (cmpIn),
    .hiByteSel(hiByteSel),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

  // R5: bus stays off whenever a result is not being read
  a_r5_bus_quiet : assert property (@(posedge clk) disable iff (!rstN)
    eocN |-> !dataOe);

endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;

  localparam int RES  = 14;
  localparam int ACQ  = 8;
  localparam int WAKE = 40;
  localparam int BITC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       rdConv = 1'b0;
  logic       hiByteSel = 1'b0;
  logic       cmpIn;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       eocN;
  logic       refOn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [RES-1:0] tgt = '0;

  always #5 clk = ~clk;

  sar_seq_ctrl #(
    .RES_BITS(RES), .ACQ_CYCLES(ACQ), .WAKE_CYCLES(WAKE), .BIT_CYCLES(BITC)
  ) u_sar_seq_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdConv(rdConv), .hiByteSel(hiByteSel),
    .cmpIn(cmpIn), .dataOut(dataOut), .dataOe(dataOe), .eocN(eocN), .refOn(refOn)
  );

  // behavioural reference: 0 idle, 1 acquire, 2 convert, 3 done, 4 read
  int mState = 0, mTimer = 0, mBit = 0, mCyc = 0, mAcc = 0, mRes = 0;
  bit mCsPrev = 1, mRefOn = 0, mEoc = 1, mOe = 0, mShut = 1;

  always_comb cmpIn = (mState == 2) ? tgt[mBit] : 1'b0;

  always @(posedge clk) begin : model
    bit fall;
    fall = mCsPrev && !csN;
    if (!rstN) begin
      mState <= 0; mCsPrev <= 1; mRefOn <= 0; mEoc <= 1; mOe <= 0; mTimer <= 0;
    end else begin
      mCsPrev <= csN;
      case (mState)
        0: if (fall && !rdConv) begin
             mState <= 1; mTimer <= mRefOn ? ACQ : WAKE; mRefOn <= 1;
           end
        1: if (mTimer > 0) mTimer <= mTimer - 1;
           else if (fall) begin
             mState <= 2; mShut <= rdConv; mBit <= RES - 1; mCyc <= 0; mAcc <= 0;
           end
        2: if (mCyc == BITC - 1) begin
             mCyc <= 0;
             mAcc <= mAcc | (int'(cmpIn) << mBit);
             if (mBit == 0) begin
               mState <= 3; mRes <= mAcc | (int'(cmpIn) << mBit); mEoc <= 0;
               if (mShut) mRefOn <= 0;
             end else mBit <= mBit - 1;
           end else mCyc <= mCyc + 1;
        3: if (fall && rdConv) begin mState <= 4; mOe <= 1; end
        4: if (csN) begin mState <= 0; mOe <= 0; mEoc <= 1; end
        default: mState <= 0;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int expOut;
      expOut = mOe ? (hiByteSel ? (mRes >> 8) : (mRes & 255)) : 0;
      chk("R4 eocN model", int'(eocN), int'(mEoc));
      chk("R3 refOn model", int'(refOn), int'(mRefOn));
      chk("R5 dataOe model", int'(dataOe), int'(mOe));
      chk("R6 dataOut model", int'(dataOut), expOut);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic csPulse(bit rc);
    rdConv = rc; csN = 1'b0;
    tick(1);
    csN = 1'b1;
    tick(1);
  endtask

  task automatic readOut(logic [RES-1:0] exp, string tag);
    rdConv = 1'b1; csN = 1'b0;
    tick(1);
    chk({tag, " R7 oe on"}, int'(dataOe), 1);
    hiByteSel = 1'b1; #1;
    chk({tag, " R6 hi byte"}, int'(dataOut), int'(exp >> 8));
    chk({tag, " R6 hi pad"}, int'(dataOut[7:6]), 0);
    hiByteSel = 1'b0; #1;
    chk({tag, " R6 lo byte"}, int'(dataOut), int'(exp[7:0]));
    csN = 1'b1;
    tick(1);
    chk({tag, " R8 oe off"}, int'(dataOe), 0);
    chk({tag, " R8 eoc high"}, int'(eocN), 1);
  endtask

  task automatic convertExact(bit rc, string tag);
    csPulse(rc);
    tick(RES * BITC - 2);
    chk({tag, " R4 eoc not yet"}, int'(eocN), 1);
    tick(1);
    chk({tag, " R4 eoc due"}, int'(eocN), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R9 eocN reset", int'(eocN), 1);
    chk("R9 refOn reset", int'(refOn), 0);
    chk("R9 dataOe reset", int'(dataOe), 0);

    // R1: fall with rdConv high is ignored
    csPulse(1'b1);
    tick(3);
    chk("R1 ignore refOn", int'(refOn), 0);
    chk("R1 ignore eocN", int'(eocN), 1);

    // mid-scale code, shutdown path with an early second edge
    tgt = 14'h2000;
    csPulse(1'b0);
    chk("R1 wake refOn", int'(refOn), 1);
    csPulse(1'b1);                       // early: R2 ignored
    tick(RES * BITC + 2);
    chk("R2 early edge ignored", int'(eocN), 1);
    chk("R5 quiet in acquire", int'(dataOe), 0);
    tick(WAKE);
    csPulse(1'b1);                       // shutdown choice
    tick(4);
    csPulse(1'b1);                       // R10 fall during conversion
    chk("R5 quiet in convert", int'(dataOut), 0);
    tick(RES * BITC);
    chk("R10 eoc after noise", int'(eocN), 0);
    chk("R3 shutdown refOn", int'(refOn), 0);
    csPulse(1'b0);                       // R7 ignored
    chk("R7 low ignored", int'(dataOe), 0);
    readOut(14'h2000, "mid");

    // full-scale code, standby choice from shutdown
    tgt = 14'h3FFF;
    csPulse(1'b0);
    tick(WAKE + 2);
    convertExact(1'b0, "full");
    chk("R3 standby refOn", int'(refOn), 1);
    readOut(14'h3FFF, "full");

    // from standby: short window
    tgt = 14'h1555;
    csPulse(1'b0);
    tick(ACQ + 2);
    convertExact(1'b0, "alt");
    readOut(14'h1555, "alt");

    tgt = 14'h0000;
    csPulse(1'b0);
    tick(1);
    csPulse(1'b0);                       // R2 early in standby window
    tick(ACQ);
    convertExact(1'b1, "zero");
    chk("R3 shutdown again", int'(refOn), 0);
    readOut(14'h0000, "zero");

    tgt = 14'h2A5C;
    csPulse(1'b0);
    tick(WAKE + 2);
    convertExact(1'b0, "mix");
    readOut(14'h2A5C, "mix");

    tick(5);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule